// File: doc/BRIEF.md
# Vectored Prioritized Interrupt Controller

This block gathers 64 level-sensitive interrupt lines and sends each one to one of two processor request outputs: a normal request or a fast request. A 32-bit register bus lets software enable or disable each source and choose where it goes. Software can also give each source a 4-bit priority, force a source active without its line, and set a priority threshold for the normal path. Software reads back the raw, pending and vector state through the same bus.

Sources are switched on and off by writing a source number to a set register or a clear register. This avoids read-modify-write sequences on the enable words. The vector registers name the winning source. For the normal path, the winner is the highest-priority pending source that the threshold lets through. For the fast path, the winner is the highest-numbered pending source. Both request outputs are registered. Read data is registered and appears one cycle after the address is presented.

Top module: `vec_irq_ctrl`

## Requirements
- R1: After reset, the following hold: control word 0, threshold register 0x1F, all enable, type, force and priority bits 0, both request outputs low, and both vector registers 0xFFFF_FFFF.
- R2: A write of value k to offset 0x08 sets the enable of source k. A write of k to offset 0x0C clears it. Every other enable bit keeps its value. A value of 64 or more changes nothing.
- R3: The enable bits can also be read and written as whole words. Offset 0x14 holds sources 0–31 and offset 0x10 holds sources 32–63, with source n at bit n mod 32.
- R4: Source n has a 4-bit priority at bits [(n%8)*4+3:(n%8)*4] of group n/8. Group g is at offset 0x20+4*(7−g), so group 0 is at 0x3C and group 7 is at 0x20. Writing one group leaves the other groups unchanged.
- R5: A source is asserted when its input line or its force bit is 1. Force bits are read/write at 0x54 (sources 0–31) and 0x50 (sources 32–63). The asserted set reads at 0x4C (low) and 0x48 (high).
- R6: The type bits are read/write at 0x1C (low) and 0x18 (high). An asserted, enabled source is pending fast if its type bit is 1 and pending normal if its type bit is 0. Pending-normal reads at 0x5C/0x58 and pending-fast reads at 0x64/0x60 (low/high).
- R7: The threshold register at 0x04 holds 5 bits. When bit 4 is 0, a pending normal source counts only if its priority is strictly greater than bits [3:0]. When bit 4 is 1, every pending normal source counts.
- R8: The normal vector at 0x40 reads {source number in [31:16], priority in [15:0]} of the counting normal source with the highest priority. A tie goes to the higher source number. The register reads 0xFFFF_FFFF when no source counts.
- R9: The fast vector at 0x44 reads {source number, priority} of the highest-numbered pending fast source, regardless of priority, or 0xFFFF_FFFF when none is pending.
- R10: The normal request output is high one cycle after any counting normal source exists. The fast request output is high one cycle after any pending fast source exists. Both fall one cycle after their condition ends.
- R11: The control word at 0x00 is a plain 32-bit read/write register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Write strobe for the register at bus_addr |
| bus_addr | input | 8 | Byte offset of the register accessed |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the offset presented in the previous cycle |
| src_in | input | 64 | Level interrupt lines, bit n is source n |
| irq_norm | output | 1 | Registered normal interrupt request |
| irq_fast | output | 1 | Registered fast interrupt request |

## Verification
The bench drives a priority tie between a low and a high source number. A picker that favours the first match would report source 4 where source 40 is expected. It steps the threshold through values just below, at and above a source's priority, and then sets bit 4. An off-by-one compare would let through, or block, a source whose priority equals the threshold. It also writes an out-of-range number to the enable set register, which a decoder that truncates the value would turn into setting source 0. Other checks sample the request outputs in the cycle before and after a line change or threshold write, catching a request that is combinational or two cycles late. A fast-source check gives the higher-numbered source the lower priority, so a fast picker that honours priority is caught.

// File: rtl/vic_pkg.sv
package vic_pkg;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned ADDR_W = 8;
  localparam int unsigned PRIO_W = 4;
  localparam int unsigned THR_W  = PRIO_W + 1;

  localparam logic [ADDR_W-1:0] OFF_CTRL    = 8'h00;
  localparam logic [ADDR_W-1:0] OFF_THR     = 8'h04;
  localparam logic [ADDR_W-1:0] OFF_EN_SET  = 8'h08;
  localparam logic [ADDR_W-1:0] OFF_EN_CLR  = 8'h0C;
  localparam logic [ADDR_W-1:0] OFF_EN_HI   = 8'h10;
  localparam logic [ADDR_W-1:0] OFF_EN_LO   = 8'h14;
  localparam logic [ADDR_W-1:0] OFF_TYP_HI  = 8'h18;
  localparam logic [ADDR_W-1:0] OFF_TYP_LO  = 8'h1C;
  localparam logic [ADDR_W-1:0] OFF_PRIO    = 8'h20;
  localparam logic [ADDR_W-1:0] OFF_VEC_N   = 8'h40;
  localparam logic [ADDR_W-1:0] OFF_VEC_F   = 8'h44;
  localparam logic [ADDR_W-1:0] OFF_RAW_HI  = 8'h48;
  localparam logic [ADDR_W-1:0] OFF_RAW_LO  = 8'h4C;
  localparam logic [ADDR_W-1:0] OFF_FRC_HI  = 8'h50;
  localparam logic [ADDR_W-1:0] OFF_FRC_LO  = 8'h54;
  localparam logic [ADDR_W-1:0] OFF_PNDN_HI = 8'h58;
  localparam logic [ADDR_W-1:0] OFF_PNDN_LO = 8'h5C;
  localparam logic [ADDR_W-1:0] OFF_PNDF_HI = 8'h60;
  localparam logic [ADDR_W-1:0] OFF_PNDF_LO = 8'h64;
endpackage

// File: rtl/vic_regfile.sv
module vic_regfile
  import vic_pkg::*;
#(
  parameter int unsigned NUM_SRC = 64
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      we,
  input  logic [ADDR_W-1:0]         addr,
  input  logic [DATA_W-1:0]         wdata,
  output logic [DATA_W-1:0]         ctrl_q,
  output logic [THR_W-1:0]          thr_q,
  output logic [NUM_SRC-1:0]        en_q,
  output logic [NUM_SRC-1:0]        typ_q,
  output logic [NUM_SRC-1:0]        frc_q,
  output logic [NUM_SRC*PRIO_W-1:0] prio_q
);
  localparam int unsigned IDX_W = $clog2(NUM_SRC);
  localparam int unsigned GRP_N = NUM_SRC * PRIO_W / DATA_W;
  localparam int unsigned GRP_W = $clog2(GRP_N);
  localparam logic [ADDR_W-1:0] PRIO_END = ADDR_W'(OFF_PRIO + 4 * GRP_N);

  logic            prio_hit;
  logic [GRP_W-1:0] grp_sel;

  assign prio_hit = (addr >= OFF_PRIO) && (addr < PRIO_END) && (addr[1:0] == 2'b00);
  // groups sit in descending order from the base offset
  assign grp_sel  = GRP_W'(GRP_N - 1) - addr[GRP_W+1:2];

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
      thr_q  <= '1;
      en_q   <= '0;
      typ_q  <= '0;
      frc_q  <= '0;
      prio_q <= '0;
    end else if (we) begin
      case (addr)
        OFF_CTRL:   ctrl_q <= wdata;
        OFF_THR:    thr_q  <= wdata[THR_W-1:0];
        OFF_EN_SET: if (wdata < NUM_SRC) en_q[wdata[IDX_W-1:0]] <= 1'b1;
        OFF_EN_CLR: if (wdata < NUM_SRC) en_q[wdata[IDX_W-1:0]] <= 1'b0;
        OFF_EN_HI:  en_q[NUM_SRC-1:DATA_W]  <= wdata;
        OFF_EN_LO:  en_q[DATA_W-1:0]        <= wdata;
        OFF_TYP_HI: typ_q[NUM_SRC-1:DATA_W] <= wdata;
        OFF_TYP_LO: typ_q[DATA_W-1:0]       <= wdata;
        OFF_FRC_HI: frc_q[NUM_SRC-1:DATA_W] <= wdata;
        OFF_FRC_LO: frc_q[DATA_W-1:0]       <= wdata;
        default: if (prio_hit) prio_q[grp_sel*DATA_W +: DATA_W] <= wdata;
      endcase
    end
  end
endmodule

// File: rtl/vic_pick.sv
module vic_pick #(
  parameter int unsigned N        = 64,
  parameter int unsigned PRIO_W   = 4,
  parameter bit          USE_PRIO = 1'b1,
  localparam int unsigned IDX_W   = $clog2(N)
) (
  input  logic [N-1:0]        req,
  input  logic [N*PRIO_W-1:0] prio,
  output logic                found,
  output logic [IDX_W-1:0]    idx,
  output logic [PRIO_W-1:0]   level
);
  // ascending scan; ">=" hands ties to the later (higher) source
  always_comb begin
    found = 1'b0;
    idx   = '0;
    level = '0;
    for (int i = 0; i < N; i++) begin
      if (req[i]) begin
        if (!USE_PRIO || !found || (prio[i*PRIO_W +: PRIO_W] >= level)) begin
          found = 1'b1;
          idx   = IDX_W'(i);
          level = prio[i*PRIO_W +: PRIO_W];
        end
      end
    end
  end
endmodule

// File: rtl/vec_irq_ctrl.sv
module vec_irq_ctrl
  import vic_pkg::*;
#(
  parameter int unsigned NUM_SRC = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [NUM_SRC-1:0] src_in,
  output logic              irq_norm,
  output logic              irq_fast
);
  localparam int unsigned IDX_W  = $clog2(NUM_SRC);
  localparam int unsigned HALF_W = DATA_W / 2;
  localparam int unsigned GRP_N  = NUM_SRC * PRIO_W / DATA_W;
  localparam int unsigned GRP_W  = $clog2(GRP_N);
  localparam logic [ADDR_W-1:0] PRIO_END = ADDR_W'(OFF_PRIO + 4 * GRP_N);

  logic [DATA_W-1:0]         ctrl_q;
  logic [THR_W-1:0]          thr_q;
  logic [NUM_SRC-1:0]        en_q, typ_q, frc_q;
  logic [NUM_SRC*PRIO_W-1:0] prio_q;

  vic_regfile #(.NUM_SRC(NUM_SRC)) u_regs (
    .clk(clk), .rst(rst), .we(bus_we), .addr(bus_addr), .wdata(bus_wdata),
    .ctrl_q(ctrl_q), .thr_q(thr_q), .en_q(en_q), .typ_q(typ_q),
    .frc_q(frc_q), .prio_q(prio_q)
  );

  logic [NUM_SRC-1:0] active, pend_n, pend_f, qual_n;
  assign active = src_in | frc_q;
  assign pend_n = active & en_q & ~typ_q;
  assign pend_f = active & en_q & typ_q;

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_thr
    assign qual_n[s] = pend_n[s] &&
      (thr_q[THR_W-1] || (prio_q[s*PRIO_W +: PRIO_W] > thr_q[PRIO_W-1:0]));
  end

  logic              hit_n, hit_f;
  logic [IDX_W-1:0]  idx_n, idx_f;
  logic [PRIO_W-1:0] lvl_n, lvl_f;

  vic_pick #(.N(NUM_SRC), .PRIO_W(PRIO_W), .USE_PRIO(1'b1)) u_pick_norm (
    .req(qual_n), .prio(prio_q), .found(hit_n), .idx(idx_n), .level(lvl_n)
  );
  vic_pick #(.N(NUM_SRC), .PRIO_W(PRIO_W), .USE_PRIO(1'b0)) u_pick_fast (
    .req(pend_f), .prio(prio_q), .found(hit_f), .idx(idx_f), .level(lvl_f)
  );

  logic [DATA_W-1:0] vec_n, vec_f;
  assign vec_n = hit_n ? {HALF_W'(idx_n), HALF_W'(lvl_n)} : '1;
  assign vec_f = hit_f ? {HALF_W'(idx_f), HALF_W'(lvl_f)} : '1;

  logic [GRP_W-1:0]  grp_rd;
  logic [DATA_W-1:0] rd_mux;
  assign grp_rd = GRP_W'(GRP_N - 1) - bus_addr[GRP_W+1:2];

  always_comb begin
    rd_mux = '0;
    case (bus_addr)
      OFF_CTRL:    rd_mux = ctrl_q;
      OFF_THR:     rd_mux = DATA_W'(thr_q);
      OFF_EN_HI:   rd_mux = en_q[NUM_SRC-1:DATA_W];
      OFF_EN_LO:   rd_mux = en_q[DATA_W-1:0];
      OFF_TYP_HI:  rd_mux = typ_q[NUM_SRC-1:DATA_W];
      OFF_TYP_LO:  rd_mux = typ_q[DATA_W-1:0];
      OFF_VEC_N:   rd_mux = vec_n;
      OFF_VEC_F:   rd_mux = vec_f;
      OFF_RAW_HI:  rd_mux = active[NUM_SRC-1:DATA_W];
      OFF_RAW_LO:  rd_mux = active[DATA_W-1:0];
      OFF_FRC_HI:  rd_mux = frc_q[NUM_SRC-1:DATA_W];
      OFF_FRC_LO:  rd_mux = frc_q[DATA_W-1:0];
      OFF_PNDN_HI: rd_mux = pend_n[NUM_SRC-1:DATA_W];
      OFF_PNDN_LO: rd_mux = pend_n[DATA_W-1:0];
      OFF_PNDF_HI: rd_mux = pend_f[NUM_SRC-1:DATA_W];
      OFF_PNDF_LO: rd_mux = pend_f[DATA_W-1:0];
      default:
        if ((bus_addr >= OFF_PRIO) && (bus_addr < PRIO_END) && (bus_addr[1:0] == 2'b00))
          rd_mux = prio_q[grp_rd*DATA_W +: DATA_W];
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
      irq_norm  <= 1'b0;
      irq_fast  <= 1'b0;
    end else begin
      bus_rdata <= rd_mux;
      irq_norm  <= hit_n;
      irq_fast  <= hit_f;
    end
  end
endmodule

// File: rtl/vic_chk.sv
module vic_chk
  import vic_pkg::*;
#(
  parameter int unsigned NUM_SRC = 64,
  localparam int unsigned IDX_W  = $clog2(NUM_SRC)
) (
  input logic               clk,
  input logic               rst,
  input logic               bus_we,
  input logic [ADDR_W-1:0]  bus_addr,
  input logic [DATA_W-1:0]  bus_wdata,
  input logic               irq_norm,
  input logic               irq_fast,
  input logic [NUM_SRC-1:0] en_q,
  input logic [THR_W-1:0]   thr_q,
  input logic [NUM_SRC-1:0] pend_n,
  input logic [NUM_SRC-1:0] pend_f
);
  AST_RESET_STATE: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (thr_q == '1) && (en_q == '0) && !irq_norm && !irq_fast); // R1
  AST_EN_SET: assert property (@(posedge clk) disable iff (rst)
    (bus_we && bus_addr == OFF_EN_SET && bus_wdata < NUM_SRC)
      |=> en_q[$past(bus_wdata[IDX_W-1:0])]); // R2
  AST_EN_CLR: assert property (@(posedge clk) disable iff (rst)
    (bus_we && bus_addr == OFF_EN_CLR && bus_wdata < NUM_SRC)
      |=> !en_q[$past(bus_wdata[IDX_W-1:0])]); // R2
  AST_FULL_BLOCK: assert property (@(posedge clk) disable iff (rst)
    (!thr_q[THR_W-1] && thr_q[THR_W-2:0] == '1) |=> !irq_norm); // R7
  AST_NORM_HAS_SOURCE: assert property (@(posedge clk) disable iff (rst)
    irq_norm |-> $past(|pend_n)); // R10
  AST_FAST_HAS_SOURCE: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_fast) |-> $past(|pend_f)); // R10
endmodule

bind vec_irq_ctrl vic_chk #(.NUM_SRC(NUM_SRC)) u_chk (
  .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .irq_norm(irq_norm), .irq_fast(irq_fast),
  .en_q(en_q), .thr_q(thr_q), .pend_n(pend_n), .pend_f(pend_f)
);

// File: tb/vec_irq_ctrl_bench.sv
module vec_irq_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int N_STEPS    = 47;

  typedef struct packed {
    logic        wr;
    logic [7:0]  a;
    logic [31:0] d;
    logic [3:0]  r;
  } step_t;

  localparam step_t STEPS [N_STEPS] = '{
    '{1'b1, 8'h08, 32'd5,         4'd2},  // R2 set source 5
    '{1'b0, 8'h14, 32'h0000_0020, 4'd2},
    '{1'b1, 8'h08, 32'd40,        4'd2},  // R2 set source 40
    '{1'b0, 8'h10, 32'h0000_0100, 4'd2},
    '{1'b1, 8'h0C, 32'd5,         4'd2},  // R2 clear source 5
    '{1'b0, 8'h14, 32'h0000_0000, 4'd2},
    '{1'b0, 8'h10, 32'h0000_0100, 4'd2},
    '{1'b1, 8'h08, 32'd64,        4'd2},  // R2 out of range
    '{1'b0, 8'h14, 32'h0000_0000, 4'd2},
    '{1'b0, 8'h10, 32'h0000_0100, 4'd2},
    '{1'b1, 8'h14, 32'h0000_00F0, 4'd3},  // R3 word write
    '{1'b0, 8'h14, 32'h0000_00F0, 4'd3},
    '{1'b1, 8'h3C, 32'h1234_0000, 4'd4},  // R4 group 0
    '{1'b0, 8'h3C, 32'h1234_0000, 4'd4},
    '{1'b1, 8'h38, 32'hDEAD_0001, 4'd4},  // R4 group 1
    '{1'b0, 8'h38, 32'hDEAD_0001, 4'd4},
    '{1'b1, 8'h28, 32'h0000_0004, 4'd4},  // R4 group 5, source 40
    '{1'b0, 8'h20, 32'h0000_0000, 4'd4},
    '{1'b1, 8'h54, 32'h0000_0050, 4'd5},  // R5 force 4, 6
    '{1'b1, 8'h50, 32'h0000_0100, 4'd5},  // R5 force 40
    '{1'b0, 8'h4C, 32'h0000_0050, 4'd5},
    '{1'b0, 8'h48, 32'h0000_0100, 4'd5},
    '{1'b0, 8'h5C, 32'h0000_0050, 4'd6},  // R6
    '{1'b0, 8'h58, 32'h0000_0100, 4'd6},
    '{1'b0, 8'h40, 32'h0028_0004, 4'd8},  // R8 tie 4 vs 40
    '{1'b1, 8'h50, 32'h0000_0000, 4'd8},
    '{1'b0, 8'h40, 32'h0004_0004, 4'd8},
    '{1'b1, 8'h04, 32'h0000_0003, 4'd7},  // R7 below
    '{1'b0, 8'h40, 32'h0004_0004, 4'd7},
    '{1'b1, 8'h04, 32'h0000_0004, 4'd7},  // R7 equal
    '{1'b0, 8'h40, 32'hFFFF_FFFF, 4'd7},
    '{1'b1, 8'h04, 32'h0000_0010, 4'd7},  // R7 bypass
    '{1'b0, 8'h40, 32'h0004_0004, 4'd7},
    '{1'b1, 8'h1C, 32'h0000_0010, 4'd6},  // R6 source 4 fast
    '{1'b0, 8'h64, 32'h0000_0010, 4'd6},
    '{1'b0, 8'h5C, 32'h0000_0040, 4'd6},
    '{1'b0, 8'h40, 32'h0006_0002, 4'd8},
    '{1'b0, 8'h44, 32'h0004_0004, 4'd9},  // R9
    '{1'b1, 8'h18, 32'h0000_0100, 4'd6},
    '{1'b1, 8'h50, 32'h0000_0100, 4'd6},
    '{1'b0, 8'h60, 32'h0000_0100, 4'd6},
    '{1'b1, 8'h28, 32'h0000_0001, 4'd9},  // R9 lower prio, higher number
    '{1'b0, 8'h44, 32'h0028_0001, 4'd9},
    '{1'b0, 8'h00, 32'h0000_0000, 4'd11}, // R11
    '{1'b1, 8'h00, 32'hA5A5_0F0F, 4'd11},
    '{1'b0, 8'h00, 32'hA5A5_0F0F, 4'd11},
    '{1'b0, 8'h04, 32'h0000_0010, 4'd7}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_we = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [63:0] src_in = '0;
  logic        irq_norm, irq_fast;
  int          n_run = 0;
  int          n_fail = 0;
  bit          done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  vec_irq_ctrl u_vec_irq_ctrl (
    .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .src_in(src_in),
    .irq_norm(irq_norm), .irq_fast(irq_fast)
  );

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got 0x%08h expected 0x%08h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_we = 1'b0; bus_addr = a;
    @(negedge clk);
    d = bus_rdata;
  endtask

  task automatic rd_chk(input string req, input logic [7:0] a, input logic [31:0] exp);
    logic [31:0] v;
    rd(a, v);
    check(req, v, exp);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog (all R) got hang expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R1 reset state
    check("R1 irq_norm", 32'(irq_norm), 32'd0);
    check("R1 irq_fast", 32'(irq_fast), 32'd0);
    rd_chk("R1 thr", 8'h04, 32'h0000_001F);
    rd_chk("R1 ctrl", 8'h00, 32'h0);
    rd_chk("R1 en_lo", 8'h14, 32'h0);
    rd_chk("R1 typ_hi", 8'h18, 32'h0);
    rd_chk("R1 prio", 8'h3C, 32'h0);
    rd_chk("R1 vec_n", 8'h40, 32'hFFFF_FFFF);
    rd_chk("R1 vec_f", 8'h44, 32'hFFFF_FFFF);

    for (int i = 0; i < N_STEPS; i++) begin
      if (STEPS[i].wr) wr(STEPS[i].a, STEPS[i].d);
      else rd_chk($sformatf("R%0d step %0d", STEPS[i].r, i), STEPS[i].a, STEPS[i].d);
    end

    // R10 both requests live after table (source 6 normal, 4/40 fast)
    check("R10 irq_norm on", 32'(irq_norm), 32'd1);
    check("R10 irq_fast on", 32'(irq_fast), 32'd1);
    wr(8'h04, 32'h0000_000F);
    check("R10 irq_norm still registered", 32'(irq_norm), 32'd1);
    @(negedge clk);
    check("R7 full threshold blocks", 32'(irq_norm), 32'd0);

    // line-driven source after a fresh reset
    do_reset();
    wr(8'h08, 32'd9);
    check("R10 idle", 32'(irq_norm), 32'd0);
    src_in[9] = 1'b1;
    check("R10 not combinational", 32'(irq_norm), 32'd0);
    @(negedge clk);
    check("R10 rises", 32'(irq_norm), 32'd1);
    rd_chk("R5 line raw", 8'h4C, 32'h0000_0200);
    rd_chk("R8 line vector", 8'h40, 32'h0009_0000);
    src_in[9] = 1'b0;
    @(negedge clk);
    check("R10 falls", 32'(irq_norm), 32'd0);
    rd_chk("R8 empty", 8'h40, 32'hFFFF_FFFF);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule